// File: doc/BRIEF.md
# Sixteen-Register Byte Machine Core

This block is a small 8-bit processor that runs programs out of a single 256-byte memory shared by code and data. It has sixteen 8-bit working registers. Every instruction is two bytes long and is split into four hex digits: the first digit selects the operation, and the other three name registers, a shift amount or an 8-bit address or constant. The core steps through three phases for every instruction. It reads the high byte, reads the low byte, then carries out the operation.

Programs are loaded from outside. While reset is held, a byte-wide write port fills the memory. Once reset is released the core starts fetching at address 00 and runs until it meets a halt. A separate combinational read port lets the environment inspect any memory cell at any time, and the program counter and a halted flag are visible as outputs. A store may overwrite bytes that are fetched later, and the fetch always sees the new contents, so self-modifying programs behave as written.

Top module: `teach_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 00, `halted` becomes 0 and all sixteen registers become 00. Memory contents are kept.
- R2: The preload port writes `pre_data` into cell `pre_addr` only when `pre_we` and `rst` are both high. A `pre_we` pulse while `rst` is low leaves memory unchanged.
- R3: Op 1 (1RXY) loads register R from cell XY. Op 2 (2RXY) loads R with the constant XY. Op 3 (3RXY) writes R into cell XY. Op 4 (40RS) copies register R (digit 2) into register S (digit 3).
- R4: Op 5 (5RST) writes (S + T) mod 256 into R.
- R5: Op 8 (8RST) writes S AND T into R, op 7 (7RST) writes S OR T into R, and op 9 (9RST) writes S XOR T into R.
- R6: Op A (AR0X) rotates register R right by X mod 8 bit positions. Bits leaving bit 0 re-enter at bit 7.
- R7: Op B (BRXY) sets the program counter to XY when register R equals register 0. Otherwise the next sequential instruction runs. B0XY therefore always jumps.
- R8: Op C halts the core. `halted` goes to 1, the program counter holds the halt address plus 2, and from then on neither the counter nor memory changes until reset.
- R9: Each fetch reads the memory contents as they are at that cycle, so an instruction overwritten by an earlier store executes in its new form.
- R10: Ops 0, 6, D, E and F change no register and no memory cell. They only advance the program counter by 2.
- R11: Every instruction takes exactly three clock cycles: high-byte fetch, low-byte fetch, execute. The program counter steps by one after each fetch, and a program of N instructions ending in a halt raises `halted` on the 3N-th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the preload port |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 8 | Preload cell address |
| pre_data | input | 8 | Preload byte |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 8 | Combinational contents of cell `dbg_addr` |
| pc | output | 8 | Current program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume that reset is held for at least one clock edge before any program runs. They also assume that preload traffic arrives only during reset, or is meant to be dropped. The bench keeps to this by raising `rst` at a falling edge and holding it through every preload write, and it releases reset only at a falling edge. Programs are built so that every run reaches a halt instruction, and each result cell is filled with EE beforehand, so a store that never happens stands out. The one deliberate preload write with reset low is issued after a halt, where the rule that it has no effect can be read back through the debug port.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int DW     = 8;
    localparam int AW     = 8;
    localparam int NREG   = 16;
    localparam int RAW    = $clog2(NREG);
    localparam int IW     = 2 * DW;
    localparam int DEPTH  = 1 << AW;

    localparam logic [3:0] OP_LOAD  = 4'h1;
    localparam logic [3:0] OP_LDI   = 4'h2;
    localparam logic [3:0] OP_STORE = 4'h3;
    localparam logic [3:0] OP_MOVE  = 4'h4;
    localparam logic [3:0] OP_ADD   = 4'h5;
    localparam logic [3:0] OP_OR    = 4'h7;
    localparam logic [3:0] OP_AND   = 4'h8;
    localparam logic [3:0] OP_XOR   = 4'h9;
    localparam logic [3:0] OP_ROR   = 4'hA;
    localparam logic [3:0] OP_JEQ   = 4'hB;
    localparam logic [3:0] OP_HALT  = 4'hC;

    typedef enum logic [1:0] {
        ST_FETCH_HI = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_EXEC     = 2'd2,
        ST_HALT     = 2'd3
    } tc_state_e;

    typedef struct packed {
        tc_state_e        state;
        logic [AW-1:0]    pc;
        logic [IW-1:0]    ir;
    } tc_core_s;
endpackage

// File: rtl/tc_regfile.sv
module tc_regfile
    import tc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr_a,
    output logic [DW-1:0]  rdata_a,
    input  logic [RAW-1:0] raddr_b,
    output logic [DW-1:0]  rdata_b,
    output logic [DW-1:0]  rdata_zero
);
    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (rst) begin
                regs_d[g] = '0;
            end else if (we && (waddr == RAW'(g))) begin
                regs_d[g] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            regs_q[g] <= regs_d[g];
        end
    end

    assign rdata_a    = regs_q[raddr_a];
    assign rdata_b    = regs_q[raddr_b];
    assign rdata_zero = regs_q[0];

    // A write lands in the addressed register on the next cycle.
    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && raddr_a == waddr) |=> (rdata_a == $past(wdata)) || $past(raddr_a) != raddr_a
    ); // R3
endmodule

// File: rtl/tc_mem.sv
module tc_mem
    import tc_pkg::*;
(
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);
    logic [DW-1:0] cells_q [DEPTH];

    logic          wr_en_d;
    logic [AW-1:0] wr_addr_d;
    logic [DW-1:0] wr_data_d;

    always_comb begin
        wr_en_d   = 1'b0;
        wr_addr_d = core_addr;
        wr_data_d = core_wdata;
        if (pre_we) begin
            wr_en_d   = 1'b1;
            wr_addr_d = pre_addr;
            wr_data_d = pre_data;
        end else if (core_we) begin
            wr_en_d   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_d) begin
            cells_q[wr_addr_d] <= wr_data_d;
        end
    end

    assign core_rdata = cells_q[core_addr];
    assign dbg_data   = cells_q[dbg_addr];

    // Preload and core traffic never compete for the write port.
    AST_ONE_WRITER: assert property (@(posedge clk) !(pre_we && core_we)); // R2
endmodule

// File: rtl/tc_alu.sv
module tc_alu
    import tc_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [3:0]    rot_amt,
    output logic [DW-1:0] result
);
    localparam int SHW = $clog2(DW);

    logic [2*DW-1:0] rot_dbl;

    always_comb begin
        rot_dbl = {opa, opa} >> rot_amt[SHW-1:0];
        unique case (op)
            OP_ADD:  result = opa + opb;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_XOR:  result = opa ^ opb;
            OP_ROR:  result = rot_dbl[DW-1:0];
            default: result = opa;
        endcase
    end
endmodule

// File: rtl/teach_cpu.sv
module teach_cpu
    import tc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [7:0]    pre_addr,
    input  logic [7:0]    pre_data,
    input  logic [7:0]    dbg_addr,
    output logic [7:0]    dbg_data,
    output logic [7:0]    pc,
    output logic          halted
);
    tc_core_s core_q, core_d;

    logic [3:0]    op;
    logic [3:0]    dig_r, dig_s, dig_t;
    logic [7:0]    imm_xy;

    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;

    logic          rf_we;
    logic [RAW-1:0] rf_waddr, rf_raddr_a;
    logic [DW-1:0] rf_wdata, rf_a, rf_b, rf_zero;
    logic [DW-1:0] alu_out;

    logic          in_exec;
    logic          take_jump;

    assign op     = core_q.ir[15:12];
    assign dig_r  = core_q.ir[11:8];
    assign dig_s  = core_q.ir[7:4];
    assign dig_t  = core_q.ir[3:0];
    assign imm_xy = core_q.ir[7:0];

    assign in_exec = (core_q.state == ST_EXEC);

    // Register read A: two-source ops and move read digit 2, others digit 1.
    always_comb begin
        unique case (op)
            OP_MOVE, OP_ADD, OP_OR, OP_AND, OP_XOR: rf_raddr_a = dig_s;
            default:                                rf_raddr_a = dig_r;
        endcase
    end

    // Register write port.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dig_r;
        rf_wdata = alu_out;
        if (in_exec && !rst) begin
            unique case (op)
                OP_LOAD: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
                OP_LDI:  begin rf_we = 1'b1; rf_wdata = imm_xy;    end
                OP_MOVE: begin rf_we = 1'b1; rf_waddr = dig_t;     end
                OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
                default: rf_we = 1'b0;
            endcase
        end
    end

    // Memory port: fetch uses PC, execute uses the XY field.
    assign mem_addr  = in_exec ? imm_xy : core_q.pc;
    assign mem_we    = in_exec && !rst && (op == OP_STORE);
    assign take_jump = (op == OP_JEQ) && (rf_a == rf_zero);

    always_comb begin
        core_d = core_q;
        if (rst) begin
            core_d.state = ST_FETCH_HI;
            core_d.pc    = '0;
            core_d.ir    = '0;
        end else begin
            unique case (core_q.state)
                ST_FETCH_HI: begin
                    core_d.ir[15:8] = mem_rdata;
                    core_d.pc       = core_q.pc + 1'b1;
                    core_d.state    = ST_FETCH_LO;
                end
                ST_FETCH_LO: begin
                    core_d.ir[7:0]  = mem_rdata;
                    core_d.pc       = core_q.pc + 1'b1;
                    core_d.state    = ST_EXEC;
                end
                ST_EXEC: begin
                    core_d.state = ST_FETCH_HI;
                    if (op == OP_HALT) begin
                        core_d.state = ST_HALT;
                    end else if (take_jump) begin
                        core_d.pc = imm_xy;
                    end
                end
                default: core_d = core_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    tc_regfile u_rf (
        .clk        (clk),
        .rst        (rst),
        .we         (rf_we),
        .waddr      (rf_waddr),
        .wdata      (rf_wdata),
        .raddr_a    (rf_raddr_a),
        .rdata_a    (rf_a),
        .raddr_b    (dig_t),
        .rdata_b    (rf_b),
        .rdata_zero (rf_zero)
    );

    tc_alu u_alu (
        .op      (op),
        .opa     (rf_a),
        .opb     (rf_b),
        .rot_amt (dig_t),
        .result  (alu_out)
    );

    tc_mem u_mem (
        .clk        (clk),
        .pre_we     (pre_we && rst),
        .pre_addr   (pre_addr),
        .pre_data   (pre_data),
        .core_we    (mem_we),
        .core_addr  (mem_addr),
        .core_wdata (rf_a),
        .core_rdata (mem_rdata),
        .dbg_addr   (dbg_addr),
        .dbg_data   (dbg_data)
    );

    assign pc     = core_q.pc;
    assign halted = (core_q.state == ST_HALT);

    AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (rst)
        (core_q.state == ST_FETCH_HI) |=> (core_q.state == ST_FETCH_LO)
    ); // R11
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (core_q.state inside {ST_FETCH_HI, ST_FETCH_LO}) |=> (pc == $past(pc) + 8'd1)
    ); // R11
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_exec && op == OP_JEQ && rf_a == rf_zero) |=> (pc == $past(imm_xy))
    ); // R7
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc))
    ); // R8
    AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we
    ); // R8
    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (pc == 8'h00 && !halted)
    ); // R1
endmodule

// File: tb/tb_teach_cpu.sv
module tb_teach_cpu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [7:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic [7:0] pc;
    logic       halted;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    teach_cpu dut (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data),
        .pc       (pc),
        .halted   (halted)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk);
        #1 pre_we = 1'b0;
    endtask

    task automatic pokew(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(a + 8'd1, w[7:0]);
    endtask

    task automatic peek(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        dbg_addr = a;
        #1 check(req, dbg_data, exp);
    endtask

    // Release reset, count edges until halted, check timing and final PC.
    task automatic run(input string req, input int exp_cycles, input logic [7:0] exp_pc);
        int cyc = 0;
        @(negedge clk);
        rst = 1'b0;
        while (cyc < 2000) begin
            @(posedge clk);
            cyc++;
            #1;
            if (halted) break;
        end
        check({req, " R11 cycles"}, cyc, exp_cycles);
        check({req, " R8 halt pc"}, pc, exp_pc);
        check({req, " R8 halted"}, halted, 1);
    endtask

    task automatic t_move_add();
        enter_reset();
        poke(8'h90, 8'hEE); poke(8'h91, 8'h5A); poke(8'h92, 8'hEE);
        pokew(8'h00, 16'h21F0);
        pokew(8'h02, 16'h2230);
        pokew(8'h04, 16'h5312);
        pokew(8'h06, 16'h3390);
        pokew(8'h08, 16'h1491);
        pokew(8'h0A, 16'h4045);
        pokew(8'h0C, 16'h3592);
        pokew(8'h0E, 16'hC000);
        run("move_add", 24, 8'h10);
        peek("R4 add wraps mod 256", 8'h90, 8'h20);
        peek("R3 load, move, store", 8'h92, 8'h5A);
    endtask

    task automatic t_logic();
        enter_reset();
        poke(8'hA0, 8'hEE); poke(8'hA1, 8'hEE); poke(8'hA2, 8'hEE);
        pokew(8'h00, 16'h21C3);
        pokew(8'h02, 16'h22A5);
        pokew(8'h04, 16'h8312);
        pokew(8'h06, 16'h7412);
        pokew(8'h08, 16'h9512);
        pokew(8'h0A, 16'h33A0);
        pokew(8'h0C, 16'h34A1);
        pokew(8'h0E, 16'h35A2);
        pokew(8'h10, 16'hC000);
        run("logic", 27, 8'h12);
        peek("R5 and", 8'hA0, 8'h81);
        peek("R5 or",  8'hA1, 8'hE7);
        peek("R5 xor", 8'hA2, 8'h66);
    endtask

    task automatic t_rotate();
        enter_reset();
        poke(8'hB0, 8'hEE); poke(8'hB1, 8'hEE); poke(8'hB2, 8'hEE);
        pokew(8'h00, 16'h2196);
        pokew(8'h02, 16'hA103);
        pokew(8'h04, 16'h31B0);
        pokew(8'h06, 16'h2296);
        pokew(8'h08, 16'hA209);
        pokew(8'h0A, 16'h32B1);
        pokew(8'h0C, 16'h2396);
        pokew(8'h0E, 16'hA308);
        pokew(8'h10, 16'h33B2);
        pokew(8'h12, 16'hC000);
        run("rotate", 30, 8'h14);
        peek("R6 rotate by 3", 8'hB0, 8'hD2);
        peek("R6 rotate by 9 acts as 1", 8'hB1, 8'h4B);
        peek("R6 rotate by 8 unchanged", 8'hB2, 8'h96);
    endtask

    task automatic t_jump();
        enter_reset();
        poke(8'hC0, 8'hEE); poke(8'hC1, 8'hEE); poke(8'hC2, 8'hEE);
        pokew(8'h00, 16'h2005);
        pokew(8'h02, 16'h2105);
        pokew(8'h04, 16'h2207);
        pokew(8'h06, 16'hB20C);   // not taken
        pokew(8'h08, 16'hB110);   // taken
        pokew(8'h0A, 16'h2377);
        pokew(8'h0C, 16'h33C0);
        pokew(8'h0E, 16'hC000);
        pokew(8'h10, 16'h24AA);
        pokew(8'h12, 16'h34C1);
        pokew(8'h14, 16'h33C0);
        pokew(8'h16, 16'hB01A);   // always taken
        pokew(8'h18, 16'h2499);
        pokew(8'h1A, 16'h34C2);
        pokew(8'h1C, 16'hC000);
        run("jump R7", 33, 8'h1E);
        peek("R7 skipped load left R3 zero", 8'hC0, 8'h00);
        peek("R7 equal-register jump taken", 8'hC1, 8'hAA);
        peek("R7 register-0 jump always", 8'hC2, 8'hAA);
    endtask

    task automatic t_selfmod();
        enter_reset();
        poke(8'hD0, 8'hEE);
        pokew(8'h00, 16'h21C0);
        pokew(8'h02, 16'h310A);
        pokew(8'h04, 16'h2200);
        pokew(8'h06, 16'h320B);
        pokew(8'h08, 16'h235A);
        pokew(8'h0A, 16'h2377);   // becomes C000
        pokew(8'h0C, 16'h33D0);
        pokew(8'h0E, 16'hC000);
        run("selfmod R9", 18, 8'h0C);
        peek("R9 rewritten instruction halted first", 8'hD0, 8'hEE);
        peek("R9 rewritten high byte", 8'h0A, 8'hC0);
    endtask

    task automatic t_nop();
        enter_reset();
        poke(8'hE0, 8'hEE); poke(8'h23, 8'h42);
        pokew(8'h00, 16'h2111);
        pokew(8'h02, 16'h0123);
        pokew(8'h04, 16'h6123);
        pokew(8'h06, 16'hD123);
        pokew(8'h08, 16'hE123);
        pokew(8'h0A, 16'hF123);
        pokew(8'h0C, 16'h31E0);
        pokew(8'h0E, 16'hC000);
        run("nop R10", 24, 8'h10);
        peek("R10 register untouched by no-ops", 8'hE0, 8'h11);
        peek("R10 memory untouched by no-ops", 8'h23, 8'h42);
    endtask

    task automatic t_halt_hold_and_preload();
        logic [7:0] pc_at_halt;
        enter_reset();
        poke(8'hE8, 8'hEE);
        pokew(8'h00, 16'h2177);
        pokew(8'h02, 16'hC000);
        pokew(8'h04, 16'h31E8);
        run("halt", 6, 8'h04);
        pc_at_halt = pc;
        // Preload strobe with reset low must be dropped.
        @(negedge clk);
        pre_we = 1'b1; pre_addr = 8'hE8; pre_data = 8'h33;
        @(posedge clk);
        #1 pre_we = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        check("R8 still halted", halted, 1);
        check("R8 pc frozen", pc, pc_at_halt);
        peek("R2 preload ignored out of reset", 8'hE8, 8'hEE);
    endtask

    task automatic t_reset();
        enter_reset();
        #1;
        check("R1 pc cleared", pc, 8'h00);
        check("R1 halted cleared", halted, 0);
        poke(8'hF0, 8'hEE);
        pokew(8'h00, 16'h35F0);   // R5 held 66 from the logic test
        pokew(8'h02, 16'hC000);
        run("reset", 6, 8'h04);
        peek("R1 registers cleared by reset", 8'hF0, 8'h00);
        peek("R1 memory kept through reset", 8'h92, 8'h5A);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_move_add();
        t_logic();
        t_rotate();
        t_jump();
        t_selfmod();
        t_nop();
        t_halt_hold_and_preload();
        t_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule